// File: doc/BRIEF.md
# Associative Tag Lookup with Least-Recently-Used Victim Hint

This block is a small fully associative tag store. It has sixteen entries. Each entry holds a 32-bit tag, a 4-bit state field and a valid flag. A lookup compares one key against every entry in the same cycle. One cycle later the block returns a 32-bit result word. That word holds three fields: a hit flag, an entry number and the entry's state. Every other bit of the word is zero.

On a hit, the entry number is the matching entry. On a miss, the entry number is the entry used least recently, so the caller can pick it as the slot to refill. The recency order is a sixteen-position list. Both a lookup hit and a tag write move the touched entry to the most-recent end of that list.

A separate port rewrites only the state bits of a named entry, which lets software-visible status change without changing which entry looks oldest.

Top module: `cam16`

## Requirements
- R1: After reset, `result_o` is 0 and `result_vld_o` is 0. All entries are invalid with tag 0 and state 0. The recency list runs from entry 0 (least recent) to entry 15 (most recent).
- R2: A lookup with `lookup_i` high in cycle N produces `result_vld_o` high and a new `result_o` in cycle N+1. The fields are: entry number at bits [6:3], hit flag at bit [7], state at bits [11:8]. Bits [2:0] and [31:12] are always 0.
- R3: On a miss, bit [7] is 0, bits [11:8] are 0000, and bits [6:3] hold the least-recently-used entry number at the time of the lookup.
- R4: On a hit, bit [7] is 1, bits [6:3] hold the matching entry, and bits [11:8] hold that entry's state.
- R5: A lookup hit moves the matching entry to the most-recent position. A tag write does the same for the written entry. A miss leaves the order unchanged. When a hit and a tag write occur in the same cycle, the hit is applied first, so the written entry ends up most recent.
- R6: An invalid entry never hits, even when its stored tag equals the key.
- R7: When several valid entries match, the lowest-numbered one is reported.
- R8: A lookup in the same cycle as a tag write or state write sees the contents from before that write. The write is visible from the next cycle.
- R9: A state-only write replaces the 4 state bits of the named entry. It leaves the tag, the valid flag and the recency order unchanged. If a tag write names the same entry in the same cycle, the tag write's state wins.
- R10: In a cycle after one with `lookup_i` low, `result_vld_o` is 0 and `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Start a lookup of `key_i` |
| key_i | input | 32 | Lookup key |
| wr_en_i | input | 1 | Write tag and state into an entry |
| wr_idx_i | input | 4 | Entry to write |
| wr_tag_i | input | 32 | Tag to store |
| wr_state_i | input | 4 | State to store with the tag |
| st_wr_i | input | 1 | Write only the state of an entry |
| st_idx_i | input | 4 | Entry for the state-only write |
| st_val_i | input | 4 | New state value |
| result_o | output | 32 | Packed lookup result |
| result_vld_o | output | 1 | Result updated this cycle |

## Verification
Every lookup result is due exactly one clock after the cycle in which `lookup_i` was sampled. Contents and recency changes from writes become visible to a lookup issued one cycle later. The bench drives inputs on the falling edge. Before the rising edge, it computes the expected word from its own model of tags, states and recency list, using the pre-edge contents. It compares at the following falling edge, one register stage later. Cycles without a lookup are checked for a held result and a low valid, which also confirms that no result appears early or late.

// File: rtl/cam16_pkg.sv
package cam16_pkg;
  // lowest bit of the packed lookup result
  localparam int unsigned RES_LSB = 3;
endpackage

// File: rtl/cam16_lru.sv
module cam16_lru #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                touch_a_i,
  input  logic [IDX_W-1:0]                    idx_a_i,
  input  logic                                touch_b_i,
  input  logic [IDX_W-1:0]                    idx_b_i,
  output logic [IDX_W-1:0]                    lru_idx_o,
  output logic [N_ENTRIES-1:0][IDX_W-1:0]     order_o
);
  typedef logic [N_ENTRIES-1:0][IDX_W-1:0] order_t;

  order_t order_q, order_a, order_d;

  // pull entry e out of the list and append it at the most-recent end
  function automatic order_t move_mru(order_t o, logic [IDX_W-1:0] e);
    order_t r;
    logic   found;
    found = 1'b0;
    for (int i = 0; i < N_ENTRIES - 1; i++) begin
      if (o[i] == e) found = 1'b1;
      r[i] = found ? o[i+1] : o[i];
    end
    r[N_ENTRIES-1] = e;
    return r;
  endfunction

  always_comb begin
    order_a = touch_a_i ? move_mru(order_q, idx_a_i) : order_q;
    order_d = touch_b_i ? move_mru(order_a, idx_b_i) : order_a;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) order_q[i] <= IDX_W'(i);
    end else begin
      order_q <= order_d;
    end
  end

  assign lru_idx_o = order_q[0];
  assign order_o   = order_q;

  logic [N_ENTRIES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < N_ENTRIES; i++) seen[order_q[i]] = 1'b1;
  end

  // list must stay a permutation of all entries
  p_order_perm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == N_ENTRIES);

  p_touch_b_mru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_b_i |=> order_q[N_ENTRIES-1] == $past(idx_b_i));

  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!touch_a_i && !touch_b_i) |=> $stable(order_q));
endmodule

// File: rtl/cam16_match.sv
module cam16_match #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned TAG_W     = 32,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_ENTRIES-1:0][TAG_W-1:0]   tags_i,
  input  logic [N_ENTRIES-1:0]              valid_i,
  input  logic [TAG_W-1:0]                  key_i,
  output logic                              hit_o,
  output logic [IDX_W-1:0]                  hit_idx_o
);
  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  // scan downward so the lowest matching entry wins
  always_comb begin
    hit_idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match;

  p_hit_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_i[hit_idx_o] && tags_i[hit_idx_o] == key_i);

  p_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match & ((N_ENTRIES'(1) << hit_idx_o) - N_ENTRIES'(1))) == '0);
endmodule

// File: rtl/cam16.sv
module cam16
  import cam16_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned TAG_W     = 32,
  parameter int unsigned ST_W      = 4,
  parameter int unsigned RES_W     = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          lookup_i,
  input  logic [TAG_W-1:0]              key_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(N_ENTRIES)-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]              wr_tag_i,
  input  logic [ST_W-1:0]               wr_state_i,
  input  logic                          st_wr_i,
  input  logic [$clog2(N_ENTRIES)-1:0]  st_idx_i,
  input  logic [ST_W-1:0]               st_val_i,
  output logic [RES_W-1:0]              result_o,
  output logic                          result_vld_o
);
  localparam int unsigned IDX_W   = $clog2(N_ENTRIES);
  localparam int unsigned HIT_POS = RES_LSB + IDX_W;
  localparam int unsigned ST_LSB  = HIT_POS + 1;
  localparam int unsigned TOP_LSB = ST_LSB + ST_W;

  logic [N_ENTRIES-1:0][TAG_W-1:0]  tags_q;
  logic [N_ENTRIES-1:0][ST_W-1:0]   state_q;
  logic [N_ENTRIES-1:0]             valid_q;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tags_q[g]  <= '0;
        state_q[g] <= '0;
        valid_q[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        tags_q[g]  <= wr_tag_i;
        state_q[g] <= wr_state_i;
        valid_q[g] <= 1'b1;
      end else if (st_wr_i && st_idx_i == IDX_W'(g)) begin
        state_q[g] <= st_val_i;
      end
    end
  end

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] lru_idx;
  logic [N_ENTRIES-1:0][IDX_W-1:0] order;

  cam16_match #(.N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tags_i    (tags_q),
    .valid_i   (valid_q),
    .key_i     (key_i),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  // hit touch first, write touch second: the written entry ends most recent
  cam16_lru #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .touch_a_i (lookup_i && hit),
    .idx_a_i   (hit_idx),
    .touch_b_i (wr_en_i),
    .idx_b_i   (wr_idx_i),
    .lru_idx_o (lru_idx),
    .order_o   (order)
  );

  logic [RES_W-1:0] res_d;
  always_comb begin
    res_d = '0;
    res_d[RES_LSB +: IDX_W] = hit ? hit_idx : lru_idx;
    res_d[HIT_POS]          = hit;
    if (hit) res_d[ST_LSB +: ST_W] = state_q[hit_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o     <= '0;
      result_vld_o <= 1'b0;
    end else begin
      result_vld_o <= lookup_i;
      if (lookup_i) result_o <= res_d;
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> result_vld_o);

  p_zero_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[RES_LSB-1:0] == '0 && result_o[RES_W-1:TOP_LSB] == '0);

  p_miss_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && !result_o[HIT_POS]) |-> result_o[ST_LSB +: ST_W] == '0);

  p_miss_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !hit && !wr_en_i) |=> $stable(order));

  p_state_wr_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr_i && !wr_en_i && !lookup_i) |=> $stable(order) && $stable(tags_q));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> !result_vld_o && $stable(result_o));
endmodule

// File: tb/cam16_bench.sv
module cam16_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup = 1'b0;
  logic [31:0] key = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0;
  logic [3:0]  wr_state = '0;
  logic        st_wr = 1'b0;
  logic [3:0]  st_idx = '0;
  logic [3:0]  st_val = '0;
  logic [31:0] result;
  logic        result_vld;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_tag [16];
  logic [3:0]  m_st  [16];
  logic        m_val [16];
  int          m_ord [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cam16 u_cam16 (
    .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .key_i(key),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_state_i(wr_state),
    .st_wr_i(st_wr), .st_idx_i(st_idx), .st_val_i(st_val),
    .result_o(result), .result_vld_o(result_vld)
  );

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void touch(int e);
    int p = 0;
    for (int i = 0; i < 16; i++) if (m_ord[i] == e) p = i;
    for (int i = p; i < 15; i++) m_ord[i] = m_ord[i+1];
    m_ord[15] = e;
  endfunction

  // drives one cycle from a falling edge, checks at the next falling edge
  task automatic cyc(string req, bit lk, logic [31:0] k, bit we, int wi, logic [31:0] wt,
                     logic [3:0] ws, bit sw, int si, logic [3:0] sv);
    logic [31:0] exp = '0;
    int h = -1;
    logic [31:0] prev = result;
    lookup = lk; key = k; wr_en = we; wr_idx = 4'(wi); wr_tag = wt; wr_state = ws;
    st_wr = sw; st_idx = 4'(si); st_val = sv;
    for (int i = 15; i >= 0; i--) if (m_val[i] && m_tag[i] == k) h = i;
    if (h >= 0) begin
      exp[6:3] = 4'(h); exp[7] = 1'b1; exp[11:8] = m_st[h];
    end else begin
      exp[6:3] = 4'(m_ord[0]);
    end
    if (lk && h >= 0) touch(h);
    if (we) touch(wi);
    if (sw) m_st[si] = sv;
    if (we) begin m_tag[wi] = wt; m_st[wi] = ws; m_val[wi] = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    lookup = 1'b0; wr_en = 1'b0; st_wr = 1'b0;
    if (lk) check(req, {result_vld, result}, {1'b1, exp});
    else check({req, " R10"}, {result_vld, result}, {1'b0, prev});
  endtask

  task automatic look(string req, logic [31:0] k);
    cyc(req, 1'b1, k, 1'b0, 0, '0, '0, 1'b0, 0, '0);
  endtask

  task automatic wr(int i, logic [31:0] t, logic [3:0] s);
    cyc("R5", 1'b0, '0, 1'b1, i, t, s, 1'b0, 0, '0);
  endtask

  function automatic logic [31:0] tag_of(int i);
    return 32'hA500_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = '0; m_st[i] = '0; m_val[i] = 1'b0; m_ord[i] = i;
    end
    repeat (3) @(negedge clk);
    check("R1", {result_vld, result}, 33'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {result_vld, result}, 33'd0);
    // R6: tag 0 stored but invalid; R1/R3 LRU is entry 0
    look("R1 R6 R3", 32'h0);
    look("R3 R5 miss keeps order", 32'h0);
    for (int j = 0; j < 16; j++) wr((j * 5) % 16, tag_of((j * 5) % 16), 4'((j * 7) % 16));
    for (int j = 0; j < 16; j++) look("R4", tag_of((j * 3) % 16));
    for (int j = 0; j < 3; j++) look("R3", 32'hDEAD_BEEF);
    // R9: state-only writes leave tag and order
    for (int j = 0; j < 16; j++) cyc("R9", 1'b0, '0, 1'b0, 0, '0, '0, 1'b1, j, ~m_st[j]);
    look("R9 R3", 32'hDEAD_BEEF);
    for (int j = 0; j < 16; j++) look("R9 R4", tag_of(j));
    // R7: duplicate tag in entries 4 and 12
    wr(12, tag_of(4), 4'hC);
    look("R7", tag_of(4));
    // R8: lookup during write of the same key misses, then hits
    cyc("R8", 1'b1, 32'h1234_5678, 1'b1, 7, 32'h1234_5678, 4'h9, 1'b0, 0, '0);
    look("R8", 32'h1234_5678);
    cyc("R8 state", 1'b1, 32'h1234_5678, 1'b0, 0, '0, '0, 1'b1, 7, 4'h2);
    look("R8 state", 32'h1234_5678);
    // R5: hit and write on different entries in one cycle
    cyc("R5", 1'b1, tag_of(2), 1'b1, 9, 32'h0BAD_F00D, 4'h1, 1'b0, 0, '0);
    look("R5", 32'hFFFF_0000);
    // R9: tag write beats state write on the same entry
    cyc("R9", 1'b0, '0, 1'b1, 3, 32'h3333_3333, 4'h5, 1'b1, 3, 4'hA);
    look("R9", 32'h3333_3333);
    // mixed sweep
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (lf[1:0])
          2'd0: look("R4 R3 sweep", m_tag[lf[7:4]]);
          2'd1: look("R3 sweep", {16'hF0F0, lf});
          2'd2: cyc("R5 R8 sweep", lf[2], m_tag[lf[11:8]], 1'b1, int'(lf[7:4]),
                    {24'h5A5A5A, 4'h0, lf[15:12]}, lf[11:8], lf[3], int'(lf[15:12]), lf[7:4]);
          default: cyc("R9 R10 sweep", 1'b0, '0, 1'b0, 0, '0, '0, 1'b1, int'(lf[7:4]), lf[11:8]);
        endcase
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule